// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Status

This block sits between the character assembler of a serial receiver and the register interface that software reads. Each finished character arrives with a small set of condition flags: parity error, framing error and end of frame. The block stores the character and its flags side by side in two queues that always move in lockstep. It can hold three characters, so software has three character times to respond before any data is lost.

On the read side there is one byte-wide read port with a select input. The status view shows the flags of the character at the head of the queue. The data view shows the character at the head of the queue. Only a data read advances the queues, so software must read the status view first and the data view second. If it reads the status after the data, it gets the flags of the following character.

The error flags are sticky in the status view. Once a character's flags have reached the head, they stay set until software issues an error-clear command. The end-of-frame flag is not sticky and always belongs to the current head.

Top module: `rx_char_fifo`

## Requirements
- R1: The buffer holds up to DEPTH (default 3) characters, and `char_avail` is high exactly while one or more characters are held.
- R2: Characters leave in the order they were written. With `rd_sel`=1, `rd_data` shows the head character.
- R3: A read with `rd_en`=1 and `rd_sel`=1 on a non-empty buffer removes the head character and its status together, so the next character and its status become the head.
- R4: A read with `rd_sel`=0 has no effect on the buffer contents or the count.
- R5: With `rd_sel`=0, `rd_data` gives the status view. Bit 3 is the end-of-frame flag of the head. Bits 2:0 are framing error, parity error and overrun. Each of bits 2:0 is the head's own flag ORed with a sticky copy. The sticky copy collects every error flag seen at the head and clears only on `err_clr`. Bits 7:4 read 0.
- R6: A write while DEPTH characters are held and no pop happens replaces the newest entry's character and flags, and sets its overrun bit. The count stays at DEPTH.
- R7: A data read on an empty buffer returns the last character removed (0 after reset) and changes no state.
- R8: A write and a pop in the same cycle both take effect, and the count is unchanged.
- R9: Synchronous active-high `rst` empties the buffer, clears `char_avail` and the sticky flags, and sets the last-removed character to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Assembled character is valid this cycle |
| wr_char | input | DW | Assembled character |
| wr_flags | input | 3 | {end_of_frame, framing_err, parity_err} |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 1 = data view (pops), 0 = status view |
| err_clr | input | 1 | Clears the sticky error flags |
| rd_data | output | DW | Selected view, combinational |
| char_avail | output | 1 | At least one character held |

## Verification
Assertions check on every cycle that:
- the count stays within DEPTH;
- a write always leaves a character available;
- a status read or an empty data read leaves the count unchanged;
- a simultaneous write and pop keep the count;
- an overflow write leaves the buffer full;
- sticky flags never drop without `err_clr`;
- reset empties the buffer.

Only the bench's scenarios can show that characters and flags stay paired in order. They also show where the overrun bit lands, that a status read taken after a data read belongs to the next character, and that an empty data read returns the last removed value. To show this, the bench runs a long pseudo-random sweep of mixed reads, writes and clears, and compares it against an arithmetic model of the queue.

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_char,
  input  logic [2:0]    wr_flags,
  input  logic          rd_en,
  input  logic          rd_sel,
  input  logic          err_clr,
  output logic [DW-1:0] rd_data,
  output logic          char_avail
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] dmem [DEPTH];
  logic [3:0]    smem [DEPTH];
  logic [PW-1:0] wp, rp, newest;
  logic [CW-1:0] cnt;
  logic [2:0]    sticky;
  logic [DW-1:0] last_q;
  logic          full, pop, ovw, push;
  logic [3:0]    head_s;

  assign char_avail = cnt != '0;
  assign full       = cnt == CW'(DEPTH);
  assign pop        = rd_en & rd_sel & char_avail;
  assign ovw        = wr_en & full & ~pop;
  assign push       = wr_en & ~ovw;
  assign newest     = (wp == '0) ? LAST : wp - PW'(1);
  assign head_s     = smem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      sticky <= '0;
      last_q <= '0;
    end else begin
      if (push) begin
        dmem[wp] <= wr_char;
        smem[wp] <= {wr_flags, 1'b0};
        wp       <= (wp == LAST) ? '0 : wp + PW'(1);
      end
      if (ovw) begin
        dmem[newest] <= wr_char;
        smem[newest] <= {wr_flags, 1'b1};
      end
      if (pop) begin
        last_q <= dmem[rp];
        rp     <= (rp == LAST) ? '0 : rp + PW'(1);
      end
      cnt    <= cnt + CW'(push) - CW'(pop);
      sticky <= err_clr ? 3'b000 : (sticky | (char_avail ? head_s[2:0] : 3'b000));
    end
  end

  logic [DW-1:0] stat_view;
  assign stat_view = {{(DW-4){1'b0}},
                      char_avail & head_s[3],
                      sticky | (char_avail ? head_s[2:0] : 3'b000)};
  assign rd_data = rd_sel ? (char_avail ? dmem[rp] : last_q) : stat_view;

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_push_avail_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> char_avail);
  p_stat_nopop_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_sel && !wr_en) |=> $stable(cnt));
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !err_clr |=> ((sticky & $past(sticky)) == $past(sticky)));
  p_overrun_full_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !(rd_en && rd_sel)) |=> full);
  p_empty_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel && !char_avail && !wr_en) |=> (!char_avail && $stable(last_q)));
  p_push_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && rd_sel && char_avail) |=> $stable(cnt));
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (cnt == '0 && sticky == 3'b000));
endmodule

// File: tb/rx_char_fifo_bench.sv
module rx_char_fifo_bench;
  logic clk = 1'b0;
  logic rst, wr_en, rd_en, rd_sel, err_clr;
  logic [7:0] wr_char, rd_data;
  logic [2:0] wr_flags;
  logic char_avail;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  rx_char_fifo u_rx_char_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char), .wr_flags(wr_flags),
    .rd_en(rd_en), .rd_sel(rd_sel), .err_clr(err_clr),
    .rd_data(rd_data), .char_avail(char_avail));

  logic [7:0] md [3];
  logic [3:0] ms [3];
  int n;
  logic [2:0] stk;
  logic [7:0] last;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    n = 0; stk = 3'b000; last = 8'h00;
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic [2:0] wf,
                      input logic re, input logic rs, input logic ec, input string tag);
    logic [7:0] exp;
    logic pop, ovw;
    @(negedge clk);
    wr_en = we; wr_char = wd; wr_flags = wf; rd_en = re; rd_sel = rs; err_clr = ec;
    #1;
    if (rs) exp = (n > 0) ? md[0] : last;
    else exp = {4'b0, (n > 0) & ms[0][3], stk | ((n > 0) ? ms[0][2:0] : 3'b000)};
    check(tag, rd_data, exp);
    check("R1", {7'b0, char_avail}, {7'b0, n > 0});
    pop = re & rs & (n > 0);
    ovw = we & (n == 3) & ~pop;
    stk = ec ? 3'b000 : (stk | ((n > 0) ? ms[0][2:0] : 3'b000));
    if (pop) begin
      last = md[0];
      md[0] = md[1]; ms[0] = ms[1];
      md[1] = md[2]; ms[1] = ms[2];
      n--;
    end
    if (ovw) begin
      md[2] = wd; ms[2] = {wf, 1'b1};
    end else if (we) begin
      md[n] = wd; ms[n] = {wf, 1'b0}; n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 0; rd_en = 0; rd_sel = 0; err_clr = 0; wr_char = 0; wr_flags = 0;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; wr_en = 0; rd_en = 0; rd_sel = 0; err_clr = 0; wr_char = 0; wr_flags = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    step(0, 8'h00, 3'b000, 0, 1, 0, "R9");
    step(0, 8'h00, 3'b000, 0, 0, 0, "R9");
    // R7 empty data read
    step(0, 8'h00, 3'b000, 1, 1, 0, "R7");
    // fill with three, parity error on second
    step(1, 8'hA1, 3'b000, 0, 0, 0, "R2");
    step(1, 8'hA2, 3'b001, 0, 0, 0, "R2");
    step(1, 8'hA3, 3'b100, 0, 0, 0, "R2");
    // R6 overrun overwrites newest
    step(1, 8'hA4, 3'b100, 0, 0, 0, "R6");
    // R4 repeated status reads do not pop
    step(0, 8'h00, 3'b000, 1, 0, 0, "R4");
    step(0, 8'h00, 3'b000, 1, 0, 0, "R4");
    step(0, 8'h00, 3'b000, 1, 1, 0, "R3");
    step(0, 8'h00, 3'b000, 1, 0, 0, "R5");
    step(0, 8'h00, 3'b000, 1, 1, 0, "R3");
    // head now overrun entry; status shows sticky parity + overrun + eof
    step(0, 8'h00, 3'b000, 1, 0, 0, "R6");
    // R8 simultaneous write and pop
    step(1, 8'hB0, 3'b010, 1, 1, 0, "R8");
    step(0, 8'h00, 3'b000, 1, 0, 0, "R5");
    step(0, 8'h00, 3'b000, 0, 0, 1, "R5");
    step(0, 8'h00, 3'b000, 0, 0, 0, "R5");
    step(0, 8'h00, 3'b000, 1, 1, 0, "R3");
    step(0, 8'h00, 3'b000, 1, 1, 0, "R7");
    step(0, 8'h00, 3'b000, 0, 0, 0, "R5");
    step(0, 8'h00, 3'b000, 0, 0, 1, "R5");
    // R9 reset while holding data
    step(1, 8'hC1, 3'b011, 0, 0, 0, "R2");
    do_reset();
    step(0, 8'h00, 3'b000, 0, 0, 0, "R9");
    step(0, 8'h00, 3'b000, 0, 1, 0, "R9");
    // pseudo-random sweep over all operation mixes
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[15:8], lfsr[7:5], lfsr[1] | lfsr[2], lfsr[3],
           (lfsr[4:1] == 4'hF), lfsr[3] ? "R3" : "R5");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule